// File: doc/BRIEF.md
# Multi-Endpoint USB FIFO Controller

This block keeps the pointers and flags for eight endpoint FIFOs of a USB device. Four carry transmit data, on endpoints 0, 5, 6 and 7. Four carry receive data, on endpoints 0, 1, 2 and 3. The RAMs sit outside the block. On each side they share one write-address bus, one read-address bus and one write-data bus. The block addresses them through two 9-bit pointers, a 3-bit select for the RAM being read, and one active-low write strobe per RAM.

Three FIFOs per side hold 64 bytes each. The fourth holds 2 KB and has two levels. Each level is a 1 KB data set made of two 512-byte RAM banks, and the two sets may have different lengths. On every FIFO the producer writes bytes and then commits them as a data set. The consumer reads the set and acknowledges it, and the acknowledge frees the space. On the transmit side the consumer can retry, which replays the set from its start. On the receive side the producer can discard the uncommitted bytes of a bad packet.

Lane numbering is the same on both sides: lane 0, 1 and 2 are the small FIFOs and lane 3 is the two-level FIFO. The transmit lanes map to endpoints 0, 5, 6 and 7. The receive lanes map to endpoints 0, 1, 2 and 3. RAM index 0 to 2 is the small FIFO of the same lane number. Index 3 and 4 are level 0, banks 0 and 1. Index 5 and 6 are level 1, banks 0 and 1.

Top module: `ep_fifo_ctrl`

## Requirements
- R1: After reset:
  - every FIFO is empty and not full;
  - no receive packet-ready bit is set;
  - all write strobes are high.
- R2: An accepted write on a side drives the strobe of exactly one RAM low in the same cycle. On small lane k that is bit k. The write pointer bus carries the byte offset, and the offsets run 0, 1, 2 and so on. The data bus carries the write data.
- R3: A small FIFO reports full once 64 bytes are written and not yet acknowledged. A write to a full FIFO drives no strobe.
- R4: A FIFO is empty while it has no committed byte left to read. Every read of a non-empty FIFO advances the read pointer by one. A read of an empty FIFO leaves the read pointer unchanged.
- R5: A transmit retry sets the read pointer of the selected FIFO back to the first byte of its unacknowledged data set.
- R6: A receive discard sets the write pointer back to the last commit point. The next write then reuses that offset.
- R7: An acknowledge releases the bytes read so far, and that clears a full flag. Write offsets wrap modulo 64 on the small FIFOs.
- R8: On the two-level FIFO, offset o within level L uses pointer value o mod 512 and RAM index 3 + 2L + (o div 512).
- R9: Committing on the two-level FIFO moves the producer to the other level, starting at offset 0. The FIFO reports full while both levels hold committed sets.
- R10: Acknowledging a set on the two-level FIFO frees its level. The consumer then moves on to the other level, starting at offset 0. A write while the producer's level is still committed drives no strobe.
- R11: Receive packet-ready bit k is high while lane k holds a committed data set that is not yet acknowledged.
- R12: Within one cycle, rewind (retry or discard) takes priority over commit or acknowledge, and those take priority over a byte write or read. The operation with lower priority is ignored.
- R13: The read select equals the RAM index of the byte at the current read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr_req | input | 1 | Write one byte into a transmit FIFO |
| tx_wr_ep | input | 2 | Transmit lane for the write and commit |
| tx_wr_data | input | 8 | Byte to write |
| tx_commit | input | 1 | Close the written bytes as a data set |
| tx_rd_req | input | 1 | Read one byte from a transmit FIFO |
| tx_rd_ep | input | 2 | Transmit lane for the read, retry and acknowledge |
| tx_retry | input | 1 | Replay the current set from its start |
| tx_ack | input | 1 | Release the bytes read |
| tx_ram_wdata | output | 8 | Shared transmit RAM write data |
| tx_ram_wptr | output | 9 | Shared transmit RAM write address |
| tx_ram_rptr | output | 9 | Shared transmit RAM read address |
| tx_ram_rsel | output | 3 | Transmit RAM picked for reading |
| tx_ram_we_n | output | 7 | Transmit RAM write strobes, active low |
| tx_full | output | 4 | Full flag per transmit lane |
| tx_empty | output | 4 | Empty flag per transmit lane |
| rx_wr_req | input | 1 | Write one byte into a receive FIFO |
| rx_wr_ep | input | 2 | Receive lane for the write, commit and discard |
| rx_wr_data | input | 8 | Byte to write |
| rx_commit | input | 1 | Close a good packet as a data set |
| rx_discard | input | 1 | Drop the uncommitted bytes |
| rx_rd_req | input | 1 | Read one byte from a receive FIFO |
| rx_rd_ep | input | 2 | Receive lane for the read and acknowledge |
| rx_ack | input | 1 | Release the bytes read |
| rx_ram_wdata | output | 8 | Shared receive RAM write data |
| rx_ram_wptr | output | 9 | Shared receive RAM write address |
| rx_ram_rptr | output | 9 | Shared receive RAM read address |
| rx_ram_rsel | output | 3 | Receive RAM picked for reading |
| rx_ram_we_n | output | 7 | Receive RAM write strobes, active low |
| rx_full | output | 4 | Full flag per receive lane |
| rx_empty | output | 4 | Empty flag per receive lane |
| rx_pkt_rdy | output | 4 | Committed set waiting, per receive lane |

## Verification
The hardest state to reach is a two-level FIFO with both levels committed, where the first set crosses the 512-byte bank boundary. The stimulus writes 600 bytes into receive lane 3 and commits them. It then commits a short second set and tries one more write, which must produce no strobe. The first set is read back while the bank select is watched as it crosses the boundary. The set is then acknowledged, and the bench checks that the consumer moves to the other level and that the freed level accepts writes again. A full small transmit FIFO is reached by writing 64 bytes. The bench then shows that a retry does not free space and that an acknowledge does.

// File: rtl/epfifo_pkg.sv
package epfifo_pkg;
    localparam int DATA_W      = 8;
    localparam int PTR_W       = 9;
    localparam int LANES       = 4;
    localparam int SMALL_LANES = 3;
    localparam int SMALL_AW    = 6;
    localparam int BIG_AW      = 10;
    localparam int BANKS       = 2 ** (BIG_AW - PTR_W);
    localparam int RAMS        = SMALL_LANES + 2 * BANKS;
    localparam int SEL_W       = $clog2(RAMS);
    localparam int LANE_W      = $clog2(LANES);

    typedef enum logic [1:0] {P_IDLE, P_WRITE, P_COMMIT, P_REWIND} prod_op_e;
    typedef enum logic [1:0] {C_IDLE, C_READ, C_ACK, C_REWIND} cons_op_e;

    typedef struct packed {
        logic [BIG_AW-1:0] wr_ofs;
        logic [BIG_AW-1:0] rd_ofs;
        logic              wr_lvl;
        logic              rd_lvl;
        logic              full;
        logic              empty;
        logic              ready;
    } lane_view_t;

    function automatic prod_op_e prod_decode(logic req, logic fin, logic rew);
        if (rew) return P_REWIND;
        if (fin) return P_COMMIT;
        if (req) return P_WRITE;
        return P_IDLE;
    endfunction

    function automatic cons_op_e cons_decode(logic req, logic fin, logic rew);
        if (rew) return C_REWIND;
        if (fin) return C_ACK;
        if (req) return C_READ;
        return C_IDLE;
    endfunction

    function automatic logic [SEL_W-1:0] ram_index(logic [LANE_W-1:0] lane, logic lvl,
                                                   logic [BIG_AW-1:0] ofs);
        logic [SEL_W-1:0] bank;
        bank = SEL_W'(ofs >> PTR_W);
        if (lane < LANE_W'(SMALL_LANES)) return SEL_W'(lane);
        return SEL_W'(SMALL_LANES) + (lvl ? SEL_W'(BANKS) : SEL_W'(0)) + bank;
    endfunction
endpackage

// File: rtl/epfifo_lane_flat.sv
module epfifo_lane_flat
    import epfifo_pkg::*;
#(
    parameter int AW = SMALL_AW
) (
    input  logic       clk,
    input  logic       rst,
    input  prod_op_e   p_op,
    input  cons_op_e   c_op,
    output lane_view_t view
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CAP = CW'(1) << AW;

    logic [CW-1:0] wr_q, cm_q, rd_q, base_q;
    logic full, empty;

    assign full  = (wr_q - base_q) == CAP;
    assign empty = (rd_q == cm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            cm_q   <= '0;
            rd_q   <= '0;
            base_q <= '0;
        end else begin
            case (p_op)
                P_WRITE:  if (!full) wr_q <= wr_q + CW'(1);
                P_COMMIT: cm_q <= wr_q;
                P_REWIND: wr_q <= cm_q;
                default:  ;
            endcase
            case (c_op)
                C_READ:   if (!empty) rd_q <= rd_q + CW'(1);
                C_ACK:    base_q <= rd_q;
                C_REWIND: rd_q <= base_q;
                default:  ;
            endcase
        end
    end

    always_comb begin
        view = '0;
        view.wr_ofs[AW-1:0] = wr_q[AW-1:0];
        view.rd_ofs[AW-1:0] = rd_q[AW-1:0];
        view.full  = full;
        view.empty = empty;
        view.ready = (cm_q != base_q);
    end
endmodule

// File: rtl/epfifo_lane_dual.sv
module epfifo_lane_dual
    import epfifo_pkg::*;
#(
    parameter int AW = BIG_AW
) (
    input  logic       clk,
    input  logic       rst,
    input  prod_op_e   p_op,
    input  cons_op_e   c_op,
    output lane_view_t view
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CAP = CW'(1) << AW;

    logic          wl_q, rl_q;
    logic [CW-1:0] wr_q, rd_q;
    logic [CW-1:0] len_q [2];
    logic [1:0]    vld_q;
    logic          full, empty;

    assign full  = vld_q[wl_q] || (wr_q == CAP);
    assign empty = !vld_q[rl_q] || (rd_q == len_q[rl_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            wl_q     <= 1'b0;
            rl_q     <= 1'b0;
            wr_q     <= '0;
            rd_q     <= '0;
            len_q[0] <= '0;
            len_q[1] <= '0;
            vld_q    <= '0;
        end else begin
            case (p_op)
                P_WRITE:  if (!full) wr_q <= wr_q + CW'(1);
                P_COMMIT: if (!vld_q[wl_q]) begin
                    len_q[wl_q] <= wr_q;
                    vld_q[wl_q] <= 1'b1;
                    wl_q        <= ~wl_q;
                    wr_q        <= '0;
                end
                P_REWIND: wr_q <= '0;
                default:  ;
            endcase
            case (c_op)
                C_READ:   if (!empty) rd_q <= rd_q + CW'(1);
                C_ACK:    if (vld_q[rl_q]) begin
                    vld_q[rl_q] <= 1'b0;
                    rl_q        <= ~rl_q;
                    rd_q        <= '0;
                end
                C_REWIND: rd_q <= '0;
                default:  ;
            endcase
        end
    end

    always_comb begin
        view = '0;
        view.wr_ofs[AW-1:0] = wr_q[AW-1:0];
        view.rd_ofs[AW-1:0] = rd_q[AW-1:0];
        view.wr_lvl = wl_q;
        view.rd_lvl = rl_q;
        view.full   = full;
        view.empty  = empty;
        view.ready  = vld_q[rl_q];
    end
endmodule

// File: rtl/epfifo_side.sv
module epfifo_side
    import epfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              wr_rewind,
    input  logic              rd_req,
    input  logic [LANE_W-1:0] rd_lane,
    input  logic              ack,
    input  logic              rd_rewind,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [PTR_W-1:0]  ram_wptr,
    output logic [PTR_W-1:0]  ram_rptr,
    output logic [SEL_W-1:0]  ram_rsel,
    output logic [RAMS-1:0]   ram_we_n,
    output logic [LANES-1:0]  full,
    output logic [LANES-1:0]  empty,
    output logic [LANES-1:0]  ready
);
    prod_op_e   p_sel;
    cons_op_e   c_sel;
    lane_view_t views [LANES];
    lane_view_t wv, rv;
    logic       wr_go;
    logic [SEL_W-1:0] widx;

    assign p_sel = prod_decode(wr_req, commit, wr_rewind);
    assign c_sel = cons_decode(rd_req, ack, rd_rewind);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        prod_op_e p_op;
        cons_op_e c_op;
        assign p_op = (wr_lane == LANE_W'(k)) ? p_sel : P_IDLE;
        assign c_op = (rd_lane == LANE_W'(k)) ? c_sel : C_IDLE;
        if (k < SMALL_LANES) begin : g_flat
            epfifo_lane_flat #(.AW(SMALL_AW)) u_lane (
                .clk(clk), .rst(rst), .p_op(p_op), .c_op(c_op), .view(views[k]));
        end else begin : g_dual
            epfifo_lane_dual #(.AW(BIG_AW)) u_lane (
                .clk(clk), .rst(rst), .p_op(p_op), .c_op(c_op), .view(views[k]));
        end
    end

    assign wv    = views[wr_lane];
    assign rv    = views[rd_lane];
    assign wr_go = (p_sel == P_WRITE) && !wv.full;
    assign widx  = ram_index(wr_lane, wv.wr_lvl, wv.wr_ofs);

    assign ram_wdata = wr_data;
    assign ram_wptr  = wv.wr_ofs[PTR_W-1:0];
    assign ram_rptr  = rv.rd_ofs[PTR_W-1:0];
    assign ram_rsel  = ram_index(rd_lane, rv.rd_lvl, rv.rd_ofs);
    assign ram_we_n  = wr_go ? ~(RAMS'(1) << widx) : '1;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            full[k]  = views[k].full;
            empty[k] = views[k].empty;
            ready[k] = views[k].ready;
        end
    end
endmodule

// File: rtl/ep_fifo_ctrl.sv
module ep_fifo_ctrl
    import epfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr_req,
    input  logic [LANE_W-1:0] tx_wr_ep,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              tx_commit,
    input  logic              tx_rd_req,
    input  logic [LANE_W-1:0] tx_rd_ep,
    input  logic              tx_retry,
    input  logic              tx_ack,
    output logic [DATA_W-1:0] tx_ram_wdata,
    output logic [PTR_W-1:0]  tx_ram_wptr,
    output logic [PTR_W-1:0]  tx_ram_rptr,
    output logic [SEL_W-1:0]  tx_ram_rsel,
    output logic [RAMS-1:0]   tx_ram_we_n,
    output logic [LANES-1:0]  tx_full,
    output logic [LANES-1:0]  tx_empty,
    input  logic              rx_wr_req,
    input  logic [LANE_W-1:0] rx_wr_ep,
    input  logic [DATA_W-1:0] rx_wr_data,
    input  logic              rx_commit,
    input  logic              rx_discard,
    input  logic              rx_rd_req,
    input  logic [LANE_W-1:0] rx_rd_ep,
    input  logic              rx_ack,
    output logic [DATA_W-1:0] rx_ram_wdata,
    output logic [PTR_W-1:0]  rx_ram_wptr,
    output logic [PTR_W-1:0]  rx_ram_rptr,
    output logic [SEL_W-1:0]  rx_ram_rsel,
    output logic [RAMS-1:0]   rx_ram_we_n,
    output logic [LANES-1:0]  rx_full,
    output logic [LANES-1:0]  rx_empty,
    output logic [LANES-1:0]  rx_pkt_rdy
);
    logic [LANES-1:0] tx_ready_unused;

    epfifo_side u_tx (
        .clk(clk), .rst(rst),
        .wr_req(tx_wr_req), .wr_lane(tx_wr_ep), .wr_data(tx_wr_data),
        .commit(tx_commit), .wr_rewind(1'b0),
        .rd_req(tx_rd_req), .rd_lane(tx_rd_ep), .ack(tx_ack), .rd_rewind(tx_retry),
        .ram_wdata(tx_ram_wdata), .ram_wptr(tx_ram_wptr), .ram_rptr(tx_ram_rptr),
        .ram_rsel(tx_ram_rsel), .ram_we_n(tx_ram_we_n),
        .full(tx_full), .empty(tx_empty), .ready(tx_ready_unused)
    );

    epfifo_side u_rx (
        .clk(clk), .rst(rst),
        .wr_req(rx_wr_req), .wr_lane(rx_wr_ep), .wr_data(rx_wr_data),
        .commit(rx_commit), .wr_rewind(rx_discard),
        .rd_req(rx_rd_req), .rd_lane(rx_rd_ep), .ack(rx_ack), .rd_rewind(1'b0),
        .ram_wdata(rx_ram_wdata), .ram_wptr(rx_ram_wptr), .ram_rptr(rx_ram_rptr),
        .ram_rsel(rx_ram_rsel), .ram_we_n(rx_ram_we_n),
        .full(rx_full), .empty(rx_empty), .ready(rx_pkt_rdy)
    );
endmodule

// File: rtl/ep_fifo_ctrl_chk.sv
module ep_fifo_ctrl_chk
    import epfifo_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tx_wr_req,
    input logic [LANE_W-1:0] tx_wr_ep,
    input logic [DATA_W-1:0] tx_wr_data,
    input logic              tx_commit,
    input logic              tx_rd_req,
    input logic [LANE_W-1:0] tx_rd_ep,
    input logic              tx_retry,
    input logic              tx_ack,
    input logic [DATA_W-1:0] tx_ram_wdata,
    input logic [PTR_W-1:0]  tx_ram_wptr,
    input logic [PTR_W-1:0]  tx_ram_rptr,
    input logic [SEL_W-1:0]  tx_ram_rsel,
    input logic [RAMS-1:0]   tx_ram_we_n,
    input logic [LANES-1:0]  tx_full,
    input logic [LANES-1:0]  tx_empty,
    input logic              rx_wr_req,
    input logic [LANE_W-1:0] rx_wr_ep,
    input logic [DATA_W-1:0] rx_wr_data,
    input logic              rx_commit,
    input logic              rx_discard,
    input logic              rx_rd_req,
    input logic [LANE_W-1:0] rx_rd_ep,
    input logic              rx_ack,
    input logic [DATA_W-1:0] rx_ram_wdata,
    input logic [PTR_W-1:0]  rx_ram_wptr,
    input logic [PTR_W-1:0]  rx_ram_rptr,
    input logic [SEL_W-1:0]  rx_ram_rsel,
    input logic [RAMS-1:0]   rx_ram_we_n,
    input logic [LANES-1:0]  rx_full,
    input logic [LANES-1:0]  rx_empty,
    input logic [LANES-1:0]  rx_pkt_rdy
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&tx_empty && &rx_empty && tx_full == '0 && rx_full == '0
                        && rx_pkt_rdy == '0)); // R1
    AST_ONE_STROBE_TX: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~tx_ram_we_n)); // R2
    AST_ONE_STROBE_RX: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~rx_ram_we_n)); // R2
    AST_NO_OVERFLOW_TX: assert property (@(posedge clk) disable iff (rst)
        tx_full[tx_wr_ep] |-> &tx_ram_we_n); // R3
    AST_NO_OVERFLOW_RX: assert property (@(posedge clk) disable iff (rst)
        rx_full[rx_wr_ep] |-> &rx_ram_we_n); // R10
    AST_EMPTY_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
        (rx_rd_req && !rx_ack && rx_empty[rx_rd_ep])
        |=> (!$stable(rx_rd_ep) || $stable(rx_ram_rptr))); // R4
    AST_READY_OR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        &(rx_pkt_rdy | rx_empty)); // R11
    AST_COMMIT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (tx_wr_req && tx_commit) |-> &tx_ram_we_n); // R12
    AST_DISCARD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rx_wr_req && rx_discard) |-> &rx_ram_we_n); // R12
endmodule

bind ep_fifo_ctrl ep_fifo_ctrl_chk u_chk (.*);

// File: tb/ep_fifo_ctrl_test.sv
module ep_fifo_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic       tx_wr_req = 0, tx_commit = 0, tx_rd_req = 0, tx_retry = 0, tx_ack = 0;
    logic [1:0] tx_wr_ep = 0, tx_rd_ep = 0;
    logic [7:0] tx_wr_data = 0;
    logic       rx_wr_req = 0, rx_commit = 0, rx_discard = 0, rx_rd_req = 0, rx_ack = 0;
    logic [1:0] rx_wr_ep = 0, rx_rd_ep = 0;
    logic [7:0] rx_wr_data = 0;
    logic [7:0] tx_ram_wdata, rx_ram_wdata;
    logic [8:0] tx_ram_wptr, tx_ram_rptr, rx_ram_wptr, rx_ram_rptr;
    logic [2:0] tx_ram_rsel, rx_ram_rsel;
    logic [6:0] tx_ram_we_n, rx_ram_we_n;
    logic [3:0] tx_full, tx_empty, rx_full, rx_empty, rx_pkt_rdy;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ep_fifo_ctrl uut (.*);

    // op: 0 idle, 1 write, 2 commit, 3 discard, 4 read, 5 ack (receive lane 1)
    // fields: op, wptr before, rptr before, strobe low, empty after, ready after
    localparam logic [23:0] VEC [13] = '{
        {3'd1, 9'd0, 9'd0, 1'b1, 1'b1, 1'b0},
        {3'd1, 9'd1, 9'd0, 1'b1, 1'b1, 1'b0},
        {3'd2, 9'd2, 9'd0, 1'b0, 1'b0, 1'b1},
        {3'd1, 9'd2, 9'd0, 1'b1, 1'b0, 1'b1},
        {3'd3, 9'd3, 9'd0, 1'b0, 1'b0, 1'b1},
        {3'd1, 9'd2, 9'd0, 1'b1, 1'b0, 1'b1},
        {3'd4, 9'd3, 9'd0, 1'b0, 1'b0, 1'b1},
        {3'd4, 9'd3, 9'd1, 1'b0, 1'b1, 1'b1},
        {3'd4, 9'd3, 9'd2, 1'b0, 1'b1, 1'b1},
        {3'd5, 9'd3, 9'd2, 1'b0, 1'b1, 1'b0},
        {3'd2, 9'd3, 9'd2, 1'b0, 1'b0, 1'b1},
        {3'd4, 9'd3, 9'd2, 1'b0, 1'b1, 1'b1},
        {3'd5, 9'd3, 9'd3, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        tx_wr_req = 0; tx_commit = 0; tx_rd_req = 0; tx_retry = 0; tx_ack = 0;
        rx_wr_req = 0; rx_commit = 0; rx_discard = 0; rx_rd_req = 0; rx_ack = 0;
    endtask

    task automatic edge_step();
        @(negedge clk);
        idle_all();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_empty", tx_empty, 15);
        chk("R1 rx_empty", rx_empty, 15);
        chk("R1 tx_full", tx_full, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_pkt_rdy", rx_pkt_rdy, 0);
        chk("R1 tx strobes", tx_ram_we_n, 127);
        chk("R1 rx strobes", rx_ram_we_n, 127);

        // table walk on receive lane 1: R4 R6 R11
        rx_wr_ep = 1; rx_rd_ep = 1;
        foreach (VEC[n]) begin
            logic [2:0] op;
            op = VEC[n][23:21];
            rx_wr_req  = (op == 3'd1);
            rx_commit  = (op == 3'd2);
            rx_discard = (op == 3'd3);
            rx_rd_req  = (op == 3'd4);
            rx_ack     = (op == 3'd5);
            rx_wr_data = 8'(n + 8'h40);
            #1;
            chk("R6 table wptr", rx_ram_wptr, int'(VEC[n][20:12]));
            chk("R4 table rptr", rx_ram_rptr, int'(VEC[n][11:3]));
            chk("R2 table strobe", rx_ram_we_n, VEC[n][2] ? 7'h7d : 7'h7f);
            edge_step();
            chk("R4 table empty", rx_empty[1], int'(VEC[n][1]));
            chk("R11 table ready", rx_pkt_rdy[1], int'(VEC[n][0]));
        end

        // transmit lane 0: fill, full, retry, acknowledge
        tx_wr_ep = 0; tx_rd_ep = 0;
        for (int i = 0; i < 64; i++) begin
            tx_wr_req = 1; tx_wr_data = 8'(i ^ 8'h5a);
            #1;
            chk("R2 tx wptr", tx_ram_wptr, i);
            chk("R2 tx strobe", tx_ram_we_n, 7'h7e);
            chk("R2 tx wdata", tx_ram_wdata, (i ^ 8'h5a) & 8'hff);
            edge_step();
        end
        chk("R3 tx full after 64", tx_full[0], 1);
        chk("R4 tx empty before commit", tx_empty[0], 1);
        tx_wr_req = 1;
        #1 chk("R3 write while full", tx_ram_we_n, 7'h7f);
        edge_step();
        tx_commit = 1;
        edge_step();
        chk("R4 tx not empty after commit", tx_empty[0], 0);
        for (int i = 0; i < 3; i++) begin
            tx_rd_req = 1;
            #1 chk("R4 tx rptr", tx_ram_rptr, i);
            edge_step();
        end
        tx_retry = 1;
        edge_step();
        chk("R5 retry rptr", tx_ram_rptr, 0);
        chk("R7 retry keeps full", tx_full[0], 1);
        for (int i = 0; i < 2; i++) begin
            tx_rd_req = 1;
            #1 chk("R5 replay rptr", tx_ram_rptr, i);
            edge_step();
        end
        tx_ack = 1;
        edge_step();
        chk("R7 ack clears full", tx_full[0], 0);
        tx_wr_req = 1;
        #1;
        chk("R7 wrapped wptr", tx_ram_wptr, 0);
        chk("R7 strobe after ack", tx_ram_we_n, 7'h7e);
        edge_step();

        // priority on transmit lane 1
        tx_wr_ep = 1; tx_rd_ep = 1;
        tx_wr_req = 1; tx_commit = 1;
        #1 chk("R12 commit beats write", tx_ram_we_n, 7'h7f);
        edge_step();
        chk("R12 lane1 empty", tx_empty[1], 1);
        tx_wr_req = 1;
        #1 chk("R12 write was ignored", tx_ram_wptr, 0);
        edge_step();
        tx_commit = 1;
        edge_step();
        tx_rd_req = 1; tx_retry = 1;
        edge_step();
        chk("R12 retry beats read", tx_ram_rptr, 0);
        tx_rd_req = 1;
        edge_step();
        chk("R4 lane1 drained", tx_empty[1], 1);

        // two-level receive lane 3
        rx_wr_ep = 3; rx_rd_ep = 3;
        for (int i = 0; i < 600; i++) begin
            rx_wr_req = 1;
            #1;
            chk("R8 level0 wptr", rx_ram_wptr, i % 512);
            chk("R8 level0 strobe", rx_ram_we_n, ~(7'd1 << (3 + i / 512)) & 7'h7f);
            edge_step();
        end
        rx_commit = 1;
        edge_step();
        chk("R11 big ready", rx_pkt_rdy[3], 1);
        for (int i = 0; i < 5; i++) begin
            rx_wr_req = 1;
            #1;
            chk("R9 level1 wptr", rx_ram_wptr, i);
            chk("R9 level1 strobe", rx_ram_we_n, 7'h5f);
            edge_step();
        end
        rx_commit = 1;
        edge_step();
        chk("R9 both levels full", rx_full[3], 1);
        rx_wr_req = 1;
        #1 chk("R10 no overwrite", rx_ram_we_n, 7'h7f);
        edge_step();
        for (int i = 0; i < 600; i++) begin
            rx_rd_req = 1;
            #1;
            chk("R13 level0 rptr", rx_ram_rptr, i % 512);
            chk("R13 level0 rsel", rx_ram_rsel, 3 + i / 512);
            edge_step();
        end
        chk("R4 level0 drained", rx_empty[3], 1);
        chk("R11 ready until ack", rx_pkt_rdy[3], 1);
        rx_ack = 1;
        edge_step();
        chk("R10 next level not empty", rx_empty[3], 0);
        chk("R10 next level rsel", rx_ram_rsel, 5);
        chk("R10 next level rptr", rx_ram_rptr, 0);
        chk("R10 freed level not full", rx_full[3], 0);
        rx_wr_req = 1;
        #1;
        chk("R9 reused level strobe", rx_ram_we_n, 7'h77);
        chk("R9 reused level wptr", rx_ram_wptr, 0);
        edge_step();
        for (int i = 0; i < 5; i++) begin
            rx_rd_req = 1;
            edge_step();
        end
        chk("R4 level1 drained", rx_empty[3], 1);
        rx_ack = 1;
        edge_step();
        chk("R11 ready cleared", rx_pkt_rdy[3], 0);
        chk("R11 uncommitted stays empty", rx_empty[3], 1);

        // transmit two-level retry
        tx_wr_ep = 3; tx_rd_ep = 3;
        for (int i = 0; i < 3; i++) begin
            tx_wr_req = 1;
            edge_step();
        end
        tx_commit = 1;
        edge_step();
        for (int i = 0; i < 2; i++) begin
            tx_rd_req = 1;
            edge_step();
        end
        chk("R4 big rptr", tx_ram_rptr, 2);
        tx_retry = 1;
        edge_step();
        chk("R5 big retry rptr", tx_ram_rptr, 0);
        chk("R13 big retry rsel", tx_ram_rsel, 3);
        for (int i = 0; i < 3; i++) begin
            tx_rd_req = 1;
            edge_step();
        end
        chk("R4 big drained", tx_empty[3], 1);

        done = 1;
        finish_run();
    end
endmodule